// File: doc/BRIEF.md
# CFI and Identifier Query Responder

This block supplies the read data that a parallel flash bank returns while it is in one of its two query modes: the identifier mode, which reports a manufacturer code and a device code, and the common flash interface (CFI) mode, which reports a fixed table of device properties. The bank is made of several identical narrow devices wired side by side. Some of these devices may be wide parts strapped into byte mode. Four small run-time width codes describe the layout: access width, bank width, device width and maximum device width. All four are given as log2 of a byte count.

For each access the block turns the bus byte address into a per-device table index. It forms the answer that one device would give and copies that answer into every device slot of the bank. A read wider than the bank is built from successive bank-wide answers. The result is registered and presented one cycle after the read strobe. The command decoder that selects the mode and the storage array both sit outside this block.

Top module: `cfi_id_responder`

## Requirements
- R1: `rd_data` and `rd_valid` update on the clock edge that samples `rd_en` high, and `rd_valid` is high for exactly those cycles. While `rd_en` is low, `rd_data` holds its last value.
- R2: The per-device index is the byte address of the bank word shifted right by `bank_lg + maxdev_lg - dev_lg`.
- R3: In CFI mode (`cfi_mode`=1), an index of 64 or more returns a zero byte. Index 63 still returns its table entry, which is 0x01.
- R4: When the device width is 1 byte and the maximum device width is larger, the CFI byte is repeated into every byte of the device slot instead of being zero-padded.
- R5: The single-device answer fills every device-width slot of the bank. In native CFI mode, each slot holds the byte in its low lane and zeros above it.
- R6: In identifier mode (`cfi_mode`=0), only the low 8 index bits are decoded. Index 0 gives `(id0<<8)|id1`, index 1 gives `(id2<<8)|id3`, and any other index gives zero. Each device contributes the low device-width bytes of that value.
- R7: Where the access is wider than the bank, bank word k (k from 0) is read at address `addr + k*bank_bytes` and placed at byte `k*bank_bytes` of `rd_data`.
- R8: The table holds 0x51,0x52,0x59 ("QRY") at indices 0x10..0x12, then 0x01,0x00 (command set) and 0x31,0x00 (extended table address) at 0x13..0x16.
- R9: The geometry entries are as follows. 0x27 holds log2 of the device size (0x16 by default). 0x2A holds the write-buffer log2, which is 0x08 for a 1-byte bank and 0x0B otherwise. 0x2C..0x30 hold 0x01, then blocks-minus-one (16 bits, low byte first), then sector bytes divided by 256 (16 bits, low byte first).
- R10: Bytes at and above the access width read as zero. An unsupported layout returns all zeros: a width code of 3, a device wider than the bank or than its maximum, or a narrowed device that is not 1 byte wide.
- R11: During and after reset, `rd_data` is zero and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| cfi_mode | input | 1 | 1 = CFI table, 0 = identifier codes |
| addr | input | ADDR_W | Bus byte address |
| acc_lg | input | 2 | log2 of access bytes |
| bank_lg | input | 2 | log2 of bank bytes |
| dev_lg | input | 2 | log2 of device bytes |
| maxdev_lg | input | 2 | log2 of the device's maximum bytes |
| id0 | input | 16 | Manufacturer code high part |
| id1 | input | 16 | Manufacturer code low part |
| id2 | input | 16 | Device code high part |
| id3 | input | 16 | Device code low part |
| rd_data | output | 32 | Registered response |
| rd_valid | output | 1 | Response valid this cycle |

## Verification
The checker assumes the width codes and the mode are stable in the cycle that `rd_en` is sampled. It also assumes that the identifier inputs only change while no read is in flight. The stimulus drives every field on the falling edge and raises `rd_en` in the same step, so each sampled access sees one coherent layout. Unsupported layouts are applied deliberately, and only through the width codes, so that the zero-response property stays meaningful.

// File: rtl/cfi_id_responder.sv
module cfi_id_responder #(
  parameter int ADDR_W         = 16,
  parameter int BLOCKS_PER_DEV = 64,
  parameter int SECTOR_BYTES   = 65536,
  parameter int TBL_LEN        = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              cfi_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc_lg,
  input  logic [1:0]        bank_lg,
  input  logic [1:0]        dev_lg,
  input  logic [1:0]        maxdev_lg,
  input  logic [15:0]       id0,
  input  logic [15:0]       id1,
  input  logic [15:0]       id2,
  input  logic [15:0]       id3,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  localparam int LANES       = 4;
  localparam int IDX_W       = $clog2(TBL_LEN);
  localparam int DEV_SIZE_LG = $clog2(BLOCKS_PER_DEV) + $clog2(SECTOR_BYTES);
  localparam logic [15:0] REGION_CNT = 16'(BLOCKS_PER_DEV - 1);
  localparam logic [15:0] REGION_SZ  = 16'(SECTOR_BYTES / 256);

  function automatic logic [7:0] tbl_byte(input logic [IDX_W-1:0] i, input logic wide_bank);
    case (int'(i))
      'h10: tbl_byte = 8'h51;
      'h11: tbl_byte = 8'h52;
      'h12: tbl_byte = 8'h59;
      'h13: tbl_byte = 8'h01;
      'h15: tbl_byte = 8'h31;
      'h1B: tbl_byte = 8'h45;
      'h1C: tbl_byte = 8'h55;
      'h1F: tbl_byte = 8'h07;
      'h20: tbl_byte = 8'h07;
      'h21: tbl_byte = 8'h0A;
      'h23: tbl_byte = 8'h04;
      'h24: tbl_byte = 8'h04;
      'h25: tbl_byte = 8'h04;
      'h27: tbl_byte = 8'(DEV_SIZE_LG);
      'h28: tbl_byte = 8'h02;
      'h2A: tbl_byte = wide_bank ? 8'h0B : 8'h08;
      'h2C: tbl_byte = 8'h01;
      'h2D: tbl_byte = REGION_CNT[7:0];
      'h2E: tbl_byte = REGION_CNT[15:8];
      'h2F: tbl_byte = REGION_SZ[7:0];
      'h30: tbl_byte = REGION_SZ[15:8];
      'h31: tbl_byte = 8'h50;
      'h32: tbl_byte = 8'h52;
      'h33: tbl_byte = 8'h49;
      'h34: tbl_byte = 8'h31;
      'h35: tbl_byte = 8'h30;
      'h3F: tbl_byte = 8'h01;
      default: tbl_byte = 8'h00;
    endcase
  endfunction

  logic        cfg_ok, narrow;
  logic [2:0]  shamt;
  logic [31:0] mfr_code, dev_code, resp;

  assign cfg_ok = (acc_lg != 2'd3) && (bank_lg != 2'd3) && (maxdev_lg != 2'd3)
               && (dev_lg <= bank_lg) && (dev_lg <= maxdev_lg)
               && ((dev_lg == maxdev_lg) || (dev_lg == 2'd0));
  assign narrow   = dev_lg != maxdev_lg;
  assign shamt    = 3'(bank_lg) + 3'(maxdev_lg) - 3'(dev_lg);
  assign mfr_code = {8'h00, id0, 8'h00} | {16'h0000, id1};
  assign dev_code = {8'h00, id2, 8'h00} | {16'h0000, id3};

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr, idx;
    logic [1:0]        m;
    logic [7:0]        cfi_b, cfi_v, id_v;
    logic [31:0]       code;

    assign lane_addr = addr + (ADDR_W'(b) & ~((ADDR_W'(1) << bank_lg) - ADDR_W'(1)));
    assign idx       = lane_addr >> shamt;
    assign m         = 2'(b) & ((2'd1 << dev_lg) - 2'd1);
    assign cfi_b     = (idx < ADDR_W'(TBL_LEN)) ? tbl_byte(idx[IDX_W-1:0], bank_lg != 2'd0) : 8'h00;
    assign cfi_v     = (narrow || m == 2'd0) ? cfi_b : 8'h00;
    assign code      = (idx[7:0] == 8'd0) ? mfr_code : (idx[7:0] == 8'd1) ? dev_code : 32'h0;
    assign id_v      = code[8*m +: 8];
    assign resp[8*b +: 8] = (cfg_ok && (b < (32'd1 << acc_lg))) ? (cfi_mode ? cfi_v : id_v) : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= resp;
    end
  end
endmodule

module cfi_id_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        cfi_mode,
  input logic [1:0]  acc_lg,
  input logic [1:0]  bank_lg,
  input logic [1:0]  dev_lg,
  input logic [1:0]  maxdev_lg,
  input logic [31:0] rd_data,
  input logic        rd_valid
);
  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid);
  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rd_data));
  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_lg == 2'd0) |=> rd_data[31:8] == 24'h0);
  // R10
  bad_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && dev_lg > bank_lg) |=> rd_data == 32'h0);
  // R4
  narrow_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cfi_mode && acc_lg == 2'd2 && bank_lg == 2'd2 && dev_lg == 2'd0 && maxdev_lg == 2'd1)
    |=> (rd_data[7:0] == rd_data[15:8]) && (rd_data[7:0] == rd_data[23:16]) && (rd_data[7:0] == rd_data[31:24]));
endmodule

bind cfi_id_responder cfi_id_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .cfi_mode(cfi_mode),
  .acc_lg(acc_lg), .bank_lg(bank_lg), .dev_lg(dev_lg), .maxdev_lg(maxdev_lg),
  .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/test_cfi_id_responder.sv
module test_cfi_id_responder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, cfi_mode = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  acc_lg = '0, bank_lg = '0, dev_lg = '0, maxdev_lg = '0;
  logic [15:0] id0 = 16'h0089, id1 = 16'h0018, id2 = 16'h0022, id3 = 16'h0017;
  logic [31:0] rd_data;
  logic        rd_valid;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfi_id_responder i_cfi_id_responder (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .cfi_mode(cfi_mode), .addr(addr),
    .acc_lg(acc_lg), .bank_lg(bank_lg), .dev_lg(dev_lg), .maxdev_lg(maxdev_lg),
    .id0(id0), .id1(id1), .id2(id2), .id3(id3), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // {cfi, acc, bank, dev, maxdev, addr, expected}
  localparam logic [56:0] VEC [NV] = '{
    {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h00000051}, // R8
    {1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0020, 32'h00000051}, // R2
    {1'b1, 2'd2, 2'd2, 2'd1, 2'd1, 16'h0044, 32'h00520052}, // R5
    {1'b1, 2'd2, 2'd2, 2'd0, 2'd1, 16'h0088, 32'h52525252}, // R4
    {1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h01595251}, // R7
    {1'b1, 2'd2, 2'd1, 2'd1, 2'd1, 16'h0058, 32'h003F0001}, // R7 R9
    {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h003F, 32'h00000001}, // R3
    {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0040, 32'h00000000}, // R3
    {1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0000, 32'h00008918}, // R6
    {1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0002, 32'h00002217}, // R6
    {1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0004, 32'h00000000}, // R6
    {1'b0, 2'd2, 2'd2, 2'd1, 2'd1, 16'h0004, 32'h22172217}, // R5
    {1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0100, 32'h00000018}, // R6
    {1'b0, 2'd2, 2'd2, 2'd2, 2'd2, 16'h0004, 32'h00002217}, // R6
    {1'b1, 2'd2, 2'd2, 2'd1, 2'd2, 16'h0010, 32'h00000000}, // R10
    {1'b1, 2'd1, 2'd0, 2'd1, 2'd1, 16'h0020, 32'h00000000}, // R10
    {1'b1, 2'd0, 2'd1, 2'd1, 2'd1, 16'h0020, 32'h00000051}, // R10
    {1'b1, 2'd1, 2'd0, 2'd0, 2'd0, 16'h002F, 32'h00000100}, // R9
    {1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0054, 32'h0000000B}, // R9
    {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h002A, 32'h00000008}, // R9
    {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0027, 32'h00000016}, // R9
    {1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 16'h0013, 32'h00310001}, // R8
    {1'b0, 2'd2, 2'd2, 2'd0, 2'd1, 16'h0008, 32'h17171717}  // R5
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 21:                 return "R8";
      1:                     return "R2";
      2, 11, 22:             return "R5";
      3:                     return "R4";
      4, 5:                  return "R7";
      6, 7:                  return "R3";
      8, 9, 10, 12, 13:      return "R6";
      14, 15, 16:            return "R10";
      default:               return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_read(logic c, logic [1:0] a, logic [1:0] b, logic [1:0] d,
                         logic [1:0] mx, logic [15:0] ad);
    @(negedge clk);
    cfi_mode = c; acc_lg = a; bank_lg = b; dev_lg = d; maxdev_lg = mx; addr = ad;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 data in reset", rd_data, 32'h0);
    check("R11 valid in reset", {31'h0, rd_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 data after reset", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_read(VEC[i][56], VEC[i][55:54], VEC[i][53:52], VEC[i][51:50], VEC[i][49:48], VEC[i][47:32]);
      check(vec_tag(i), rd_data, VEC[i][31:0]);
      check("R1 valid after strobe", {31'h0, rd_valid}, 32'h1);
    end

    // R1 hold: inputs change with no strobe
    held = rd_data;
    cfi_mode = 1'b1; acc_lg = 2'd0; bank_lg = 2'd0; dev_lg = 2'd0; maxdev_lg = 2'd0; addr = 16'h0010;
    @(negedge clk);
    check("R1 data held", rd_data, held);
    check("R1 valid low", {31'h0, rd_valid}, 32'h0);

    // R1 latency: nothing changes before the sampling edge
    rd_en = 1'b1;
    #1;
    check("R1 no early update", rd_data, held);
    @(negedge clk);
    rd_en = 1'b0;
    check("R1 one-cycle update", rd_data, 32'h00000051);

    // R11 reset clears a nonzero response
    rst_n = 1'b0;
    #1;
    check("R11 async clear", rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule